// File: doc/BRIEF.md
# Serial Tone-Command Receiver

This block takes tone commands from a host controller over a two-wire synchronous link (a serial clock and a data line) qualified by an active-low chip enable. It brings the three host-side inputs into the system clock domain through two-flop synchronizers. It shifts in one bit on each falling edge of the synchronized serial clock. After five bits it decodes the command into a tone request for a downstream tone synthesizer.

The request names a row frequency index and a column frequency index, and says which of the two tones are active. A separate flag reports silence. Commands come in two pages, chosen by the most significant bit. The lower page holds the sixteen dual-tone keypad digits, in an irregular order. The upper page holds the eight single tones and the stop code. Codes that are not defined are discarded, and the request in force stays as it was. While chip enable is high, the receiver is held empty and the request is silent.

Top module: `tone_cmd_rx`

## Requirements
- R1: A command is 5 bits long and arrives least significant bit first, so the fifth bit received is bit 4 of the code.
- R2: Each bit is taken from the data line as it stands at a falling edge of the serial clock. Changes of the data line while the serial clock is low or high have no other effect.
- R3: Codes 1 to 9 (digits 1 to 9) request a dual tone with row index (code-1)/3 and column index (code-1)%3. Row indices 0..3 stand for 697, 770, 852 and 941 Hz. Column indices 0..3 stand for 1209, 1336, 1477 and 1633 Hz.
- R4: Code 10 requests row 3 with column 1, code 11 requests row 3 with column 0, and code 12 requests row 3 with column 2. Codes 13, 14 and 15 request rows 0, 1 and 2 with column 3. Code 0 requests row 3 with column 3. All of these set both enables.
- R5: Codes 16 to 19 request the single row tone code-16: row enable set, column enable clear. Codes 20 to 23 request the single column tone code-20: column enable set, row enable clear.
- R6: Code 31 is the stop code. It sets the off flag, clears both enables, and sets both indices to 0.
- R7: Unused codes 24 to 30 leave the request exactly as it was.
- R8: While chip enable is high, the bit count and the partial command are cleared and the request is forced silent (off flag set, both enables clear, indices 0). A partial command is not resumed after chip enable falls again.
- R9: The request changes only when a fifth bit completes a command. After four bits it is still unchanged.
- R10: A new request appears at the outputs no later than 4 system clock cycles after the fifth falling edge of the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Host chip enable, active low, asynchronous to clk |
| ser_clk | input | 1 | Host serial clock, idles high, asynchronous to clk |
| ser_data | input | 1 | Host serial data |
| tone_row | output | 2 | Row frequency index |
| tone_col | output | 2 | Column frequency index |
| row_on | output | 1 | Row tone active |
| col_on | output | 1 | Column tone active |
| tone_off | output | 1 | No tone requested |

## Verification
A wrong bit count or a wrong shift direction places the decoded code in the wrong position. Such a fault shows up as a wrong row, column or enable on the very first command after reset, within a few cycles of its fifth edge. A shift register that is not cleared when chip enable goes high only shows up on the first full command after a partial one. A decode fault in one code shows up only when that exact code is sent. For this reason every one of the 32 codes is sent, each one checked against the request that was in force before it.

// File: rtl/tone_cmd_pkg.sv
// Shared types and constants for the serial tone-command receiver.
// Assumes a 2-bit index for each of the row and column tone groups.
package tone_cmd_pkg;

    localparam int CODE_W = 5;
    localparam int IDX_W  = 2;

    typedef struct packed {
        logic [IDX_W-1:0] row;
        logic [IDX_W-1:0] col;
        logic             row_on;
        logic             col_on;
        logic             off;
    } tone_req_t;

    localparam tone_req_t REQ_SILENT = '{row: '0, col: '0, row_on: 1'b0, col_on: 1'b0, off: 1'b1};

endpackage

// File: rtl/tone_cmd_sync.sv
// Bank of two-flop synchronizers, one per input bit.
// Assumes the inputs are level signals held for several clk cycles.
// RST_VAL gives each bit's value after reset.
module tone_cmd_sync #(
    parameter int                N       = 3,
    parameter logic [N-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] d_sync
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            logic meta_q, sync_q;
            // Two-stage capture of one asynchronous bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[g];
                    sync_q <= RST_VAL[g];
                end else begin
                    meta_q <= d_async[g];
                    sync_q <= meta_q;
                end
            end
            assign d_sync[g] = sync_q;
        end
    endgenerate

endmodule

// File: rtl/tone_cmd_shifter.sv
// Assembles LSB-first commands of W bits, one bit per strobe.
// Raises done for one cycle together with the completed code.
// Assumes the strobe is a single-cycle pulse. A clear discards the partial command.
module tone_cmd_shifter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         strobe,
    input  logic         din,
    output logic         done,
    output logic [W-1:0] code
);

    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [W-2:0]     part_q;

    // Count bits, shift toward the LSB and hand over the full command.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q  <= '0;
            part_q <= '0;
            done   <= 1'b0;
            code   <= '0;
        end else begin
            done <= 1'b0;
            if (strobe) begin
                if (cnt_q == LAST) begin
                    code  <= {din, part_q};
                    done  <= 1'b1;
                    cnt_q <= '0;
                end else begin
                    part_q <= {din, part_q[W-2:1]};
                    cnt_q  <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tone_cmd_decode.sv
// Combinational map from a 5-bit command to a tone request.
// valid is low for the unused codes 24..30.
module tone_cmd_decode
    import tone_cmd_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic              valid,
    output tone_req_t         req
);

    int unsigned k;

    // Select the page by the MSB, then decode the digit or the single tone.
    always_comb begin
        valid      = 1'b1;
        req        = REQ_SILENT;
        k          = 0;
        if (!code[CODE_W-1]) begin
            req.off    = 1'b0;
            req.row_on = 1'b1;
            req.col_on = 1'b1;
            unique case (code[3:0])
                4'd0:    begin req.row = 2'd3; req.col = 2'd3; end
                4'd10:   begin req.row = 2'd3; req.col = 2'd1; end
                4'd11:   begin req.row = 2'd3; req.col = 2'd0; end
                4'd12:   begin req.row = 2'd3; req.col = 2'd2; end
                4'd13, 4'd14, 4'd15:
                         begin req.row = IDX_W'(code[3:0] - 4'd13); req.col = 2'd3; end
                default: begin
                    k       = 32'(code[3:0]) - 1;
                    req.row = IDX_W'(k / 3);
                    req.col = IDX_W'(k % 3);
                end
            endcase
        end else if (code == 5'd31) begin
            req = REQ_SILENT;
        end else if (code[3]) begin
            valid = 1'b0;
        end else if (!code[2]) begin
            req.off    = 1'b0;
            req.row_on = 1'b1;
            req.row    = code[1:0];
        end else begin
            req.off    = 1'b0;
            req.col_on = 1'b1;
            req.col    = code[1:0];
        end
    end

endmodule

// File: rtl/tone_cmd_rx.sv
// Top level: synchronizes the host link, detects falling serial-clock edges,
// assembles commands and holds the decoded tone request.
// Assumes the serial clock is much slower than clk (at least 8 clk cycles per phase).
module tone_cmd_rx
    import tone_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             ser_clk,
    input  logic             ser_data,
    output logic [IDX_W-1:0] tone_row,
    output logic [IDX_W-1:0] tone_col,
    output logic             row_on,
    output logic             col_on,
    output logic             tone_off
);

    logic [2:0]        sync_w;
    logic              ce_hi, sclk_s, sdat_s, sclk_d, fall;
    logic              done;
    logic [CODE_W-1:0] code;
    logic              dec_valid;
    tone_req_t         dec_req, req_q;

    tone_cmd_sync #(.N(3), .RST_VAL(3'b011)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ser_data, ser_clk, ce_n}),
        .d_sync  (sync_w)
    );
    assign ce_hi  = sync_w[0];
    assign sclk_s = sync_w[1];
    assign sdat_s = sync_w[2];

    // Delayed copy of the synchronized serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= sclk_s;
    end
    assign fall = sclk_d & ~sclk_s;

    tone_cmd_shifter #(.W(CODE_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ce_hi),
        .strobe (fall),
        .din    (sdat_s),
        .done   (done),
        .code   (code)
    );

    tone_cmd_decode u_dec (
        .code  (code),
        .valid (dec_valid),
        .req   (dec_req)
    );

    // Hold the request: silent while disabled, updated on each valid command.
    always_ff @(posedge clk) begin
        if (!rst_n || ce_hi)        req_q <= REQ_SILENT;
        else if (done && dec_valid) req_q <= dec_req;
    end

    assign tone_row = req_q.row;
    assign tone_col = req_q.col;
    assign row_on   = req_q.row_on;
    assign col_on   = req_q.col_on;
    assign tone_off = req_q.off;

endmodule

// File: rtl/tone_cmd_rx_chk.sv
// Property checker for tone_cmd_rx, attached through bind.
module tone_cmd_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       ce_hi,
    input logic       done,
    input logic [6:0] req_bits
);

    // req_bits = {row[1:0], col[1:0], row_on, col_on, off}
    // R6: silence never coexists with an active tone
    a_r6_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        req_bits[0] |-> (req_bits[2:1] == 2'b00 && req_bits[6:3] == 4'd0));

    // R5: a sounding request always has at least one tone enabled
    a_r5_some_tone: assert property (@(posedge clk) disable iff (!rst_n)
        !req_bits[0] |-> (req_bits[2:1] != 2'b00));

    // R8: chip enable held high for three cycles forces silence
    a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && $past(ce_n, 1) && $past(ce_n, 2) && $past(ce_n, 3)) |-> (req_bits == 7'b0000001));

    // R9: no completed command and enabled -> request holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !ce_hi) |=> $stable(req_bits));

    // R7, R9: a change of request is always preceded by a completion or a disable
    a_r7_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (req_bits != $past(req_bits)) |-> ($past(done) || $past(ce_hi)));

endmodule

bind tone_cmd_rx tone_cmd_rx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .ce_hi    (ce_hi),
    .done     (done),
    .req_bits ({tone_row, tone_col, row_on, col_on, tone_off})
);

// File: tb/tone_cmd_rx_tb_top.sv
module tone_cmd_rx_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1;
    logic ser_clk = 1'b1;
    logic ser_data = 1'b0;
    logic [1:0] tone_row, tone_col;
    logic row_on, col_on, tone_off;

    int n_chk = 0;
    int n_bad = 0;
    logic finished = 1'b0;

    logic [6:0] exp_q;

    always #4 clk = ~clk;

    tone_cmd_rx dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .tone_row(tone_row), .tone_col(tone_col), .row_on(row_on), .col_on(col_on),
        .tone_off(tone_off)
    );

    localparam logic [6:0] SILENT = 7'b0000001;

    // Expected request {row,col,row_on,col_on,off}; bit 7 = code is used.
    function automatic logic [7:0] model(input int c);
        int r, q;
        r = 0; q = 0;
        if (c >= 1 && c <= 9) begin r = (c - 1) / 3; q = (c - 1) % 3; return {1'b1, 2'(r), 2'(q), 3'b110}; end
        if (c == 10) return {1'b1, 2'd3, 2'd1, 3'b110};
        if (c == 11) return {1'b1, 2'd3, 2'd0, 3'b110};
        if (c == 12) return {1'b1, 2'd3, 2'd2, 3'b110};
        if (c >= 13 && c <= 15) return {1'b1, 2'(c - 13), 2'd3, 3'b110};
        if (c == 0) return {1'b1, 2'd3, 2'd3, 3'b110};
        if (c >= 16 && c <= 19) return {1'b1, 2'(c - 16), 2'd0, 3'b100};
        if (c >= 20 && c <= 23) return {1'b1, 2'd0, 2'(c - 20), 3'b010};
        if (c == 31) return {1'b1, SILENT};
        return 8'h00;
    endfunction

    task automatic check(input logic [6:0] exp, input string req);
        logic [6:0] act;
        act = {tone_row, tone_col, row_on, col_on, tone_off};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // One bit: data set while high, falling edge, then data disturbed while low (R2).
    task automatic send_bit(input logic b);
        @(negedge clk); ser_data = b;
        repeat (10) @(negedge clk); ser_clk = 1'b0;
        repeat (5) @(negedge clk); ser_data = ~b;
        repeat (5) @(negedge clk); ser_clk = 1'b1;
    endtask

    task automatic send_bits(input int c, input int n);
        for (int i = 0; i < n; i++) send_bit(c[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] m;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(SILENT, "R8 reset state");
        ce_n = 1'b0;
        repeat (4) @(negedge clk);
        exp_q = SILENT;

        // R1..R7, R10: every code, compared with the request before it
        for (int c = 0; c < 32; c++) begin
            send_bits(c, 5);
            m = model(c);
            if (m[7]) exp_q = m[6:0];
            check(exp_q, c >= 24 && c <= 30 ? "R7 unused code" :
                         c == 31 ? "R6 stop code" :
                         c >= 16 ? "R5 single tone" :
                         (c >= 1 && c <= 9) ? "R3 digit" : "R4 special digit");
        end

        // R10 latency: sample 4 cycles after the fifth falling edge
        send_bits(7, 5);
        send_bits(22, 4);
        @(negedge clk); ser_data = 1'b1;
        repeat (10) @(negedge clk); ser_clk = 1'b0;
        repeat (4) @(negedge clk);
        check({2'd0, 2'd2, 3'b010}, "R10 latency");
        repeat (6) @(negedge clk); ser_clk = 1'b1;

        // R9: four bits leave the request alone, the fifth commits
        send_bits(5, 5);
        check({2'd1, 2'd1, 3'b110}, "R1 digit 5");
        send_bits(16, 4);
        check({2'd1, 2'd1, 3'b110}, "R9 four bits");
        send_bit(1'b1);
        check({2'd0, 2'd0, 3'b100}, "R9 fifth bit");

        // R8: chip enable high silences and drops a partial command
        send_bits(12, 3);
        ce_n = 1'b1;
        repeat (6) @(negedge clk);
        check(SILENT, "R8 disable silent");
        ce_n = 1'b0;
        repeat (4) @(negedge clk);
        send_bits(9, 5);
        check({2'd2, 2'd2, 3'b110}, "R8 partial dropped");

        // R8: re-enable alone stays silent
        ce_n = 1'b1; repeat (6) @(negedge clk); ce_n = 1'b0; repeat (6) @(negedge clk);
        check(SILENT, "R8 re-enable silent");

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule